// File: doc/BRIEF.md
# Large-Page NAND Command Sequencer

This block turns one request (an opcode, an optional column and an optional page row) into the command and address cycles that a NAND device with pages larger than 512 bytes expects. Each cycle leaves as one beat on a valid/ready stream: a byte with a command-latch flag or an address-latch flag. A bus-timing engine downstream drives the pins. That engine also reports the device ready/busy line back through `dev_rdy_i`.

Large-page devices have no separate pointer to the spare area, so a spare-area read request becomes a normal page read with the column moved past the main page. Page reads and random data output take a second, confirming command cycle. When the last beat has been taken, the block does one of three things: it goes idle at once, it counts out a change-column delay, or it waits a short write-to-busy interval and then holds until the device reports ready. `busy_o` covers the whole operation, and a request is only accepted while it is low.

Top module: `nand_lp_seq`

## Requirements
- R1: A spare-area read request (opcode 0x50) is emitted as a page read: command 0x00, column plus PAGE_BYTES, and then the 0x30 confirm cycle.
- R2: A present column goes out as two address beats, bits 7:0 first and then bits 15:8. Only one beat (bits 7:0) goes out for the 8-bit-only opcodes 0x90, 0xEC, 0xEE and 0xEF. A command beat has the command flag set and the address flag clear. An address beat has the reverse.
- R3: When `cfg_bus16_i` is high, the column is shifted right by one before it is sent, unless the opcode is 8-bit-only.
- R4: A present row goes out as address beats for bits 7:0 and then 15:8, followed by bits 23:16 only when `cfg_row3_i` is high. All row beats come after all column beats.
- R5: A page read (0x00) that carries a column or a row ends with a 0x30 command beat, then TWB_CYC busy cycles, then a wait that ends the cycle after `dev_rdy_i` is sampled high. A page read with no address is a single command beat with no wait.
- R6: A random data output request (0x05) ends with a 0xE0 command beat and then the change-column delay. It never enters the ready wait.
- R7: A random data input request (0x85) needs only the change-column delay. The delay is `cfg_ccs_cyc_i` cycles, or DEFAULT_CCS_CYC when that input is 0. No delay is inserted when `cfg_ccs_en_i` is low, and this also applies to R6.
- R8: Opcodes 0x15, 0x10, 0x60, 0xD0, 0x80, 0x70, 0x90 and 0xEF drop `busy_o` in the cycle after their last beat is taken.
- R9: Every other opcode, reset (0xFF) included, uses the TWB_CYC interval followed by the ready wait of R5.
- R10: `busy_o` goes high on the cycle after a request is accepted and stays high until the operation ends. A beat that is offered but not taken keeps its byte and flags.
- R11: After reset the block is idle: `busy_o`, `beat_valid_o` and `wait_rb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present; taken when busy_o is low |
| req_op_i | input | 8 | Requested opcode |
| req_col_vld_i | input | 1 | Column is present |
| req_col_i | input | 16 | Column in bytes |
| req_row_vld_i | input | 1 | Row is present |
| req_row_i | input | 24 | Page row |
| cfg_bus16_i | input | 1 | Device has a 16-bit data bus |
| cfg_row3_i | input | 1 | Device takes three row bytes |
| cfg_ccs_en_i | input | 1 | Insert the change-column delay |
| cfg_ccs_cyc_i | input | 8 | Change-column delay in cycles, 0 selects the default |
| busy_o | output | 1 | Operation in progress |
| beat_valid_o | output | 1 | Beat offered |
| beat_ready_i | input | 1 | Beat taken |
| beat_byte_o | output | 8 | Beat byte |
| beat_cle_o | output | 1 | Beat is a command cycle |
| beat_ale_o | output | 1 | Beat is an address cycle |
| wait_rb_o | output | 1 | Waiting for the device to report ready |
| dev_rdy_i | input | 1 | Device ready/busy line, high when ready |

## Verification
The block keeps a captured beat list, a beat index and a post-action state. If the list or the index is wrong, the error shows at the ports on the first beat handshake, as a wrong byte, a wrong flag or a wrong beat count. If the post-action state is wrong, the error shows in the cycles after the last beat: `busy_o` stays high for the wrong number of cycles, or `wait_rb_o` rises for an opcode that must never wait. It can also show as a release before `dev_rdy_i` is high. The bench counts these cycles exactly for every request, so an error in the tail shows up within one delay period.

// File: rtl/nand_lp_pkg.sv
package nand_lp_pkg;
  localparam logic [7:0] OP_READ0      = 8'h00;
  localparam logic [7:0] OP_RD_CONFIRM = 8'h30;
  localparam logic [7:0] OP_SPARE_RD   = 8'h50;
  localparam logic [7:0] OP_RND_OUT    = 8'h05;
  localparam logic [7:0] OP_RNDO_CONF  = 8'hE0;
  localparam logic [7:0] OP_RND_IN     = 8'h85;
  localparam logic [7:0] OP_PROG       = 8'h10;
  localparam logic [7:0] OP_CACHE_PROG = 8'h15;
  localparam logic [7:0] OP_ERASE_A    = 8'h60;
  localparam logic [7:0] OP_ERASE_B    = 8'hD0;
  localparam logic [7:0] OP_DATA_IN    = 8'h80;
  localparam logic [7:0] OP_STATUS     = 8'h70;
  localparam logic [7:0] OP_ID         = 8'h90;
  localparam logic [7:0] OP_PARAM      = 8'hEC;
  localparam logic [7:0] OP_GET_FEAT   = 8'hEE;
  localparam logic [7:0] OP_SET_FEAT   = 8'hEF;

  typedef struct packed {
    logic [7:0] data;
    logic       cle;
    logic       ale;
  } beat_t;

  typedef enum logic [1:0] {POST_NONE, POST_CCS, POST_RB} post_e;

  function automatic logic op_narrow(input logic [7:0] op);
    return (op == OP_ID) || (op == OP_PARAM) || (op == OP_GET_FEAT) || (op == OP_SET_FEAT);
  endfunction
endpackage

// File: rtl/nand_lp_plan.sv
module nand_lp_plan
  import nand_lp_pkg::*;
#(
  parameter int PAGE_BYTES      = 2048,
  parameter int COL_W           = 16,
  parameter int ROW_W           = 24,
  parameter int CCS_W           = 8,
  parameter int DEFAULT_CCS_CYC = 125,
  parameter int MAX_BEATS       = 7,
  parameter int CNT_W           = $clog2(MAX_BEATS + 1)
) (
  input  logic [7:0]       op_i,
  input  logic             col_vld_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             row_vld_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             bus16_i,
  input  logic             row3_i,
  input  logic             ccs_en_i,
  input  logic [CCS_W-1:0] ccs_cyc_i,
  output beat_t            beats_o [MAX_BEATS],
  output logic [CNT_W-1:0] count_o,
  output post_e            post_o,
  output logic [15:0]      ccs_len_o
);
  localparam logic [COL_W-1:0] SPARE_OFS = COL_W'(PAGE_BYTES);

  logic [7:0]       op_eff;
  logic [COL_W-1:0] col_eff;
  logic             narrow;
  post_e            post_ccs;

  always_comb begin
    op_eff  = op_i;
    col_eff = col_i;
    if (op_i == OP_SPARE_RD) begin
      op_eff  = OP_READ0;
      col_eff = col_i + SPARE_OFS;
    end
    narrow = op_narrow(op_eff);
    if (bus16_i && !narrow) col_eff = col_eff >> 1;
  end

  assign post_ccs  = ccs_en_i ? POST_CCS : POST_NONE;
  assign ccs_len_o = (ccs_cyc_i == '0) ? 16'(DEFAULT_CCS_CYC) : 16'(ccs_cyc_i);

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < MAX_BEATS; i++) beats_o[i] = '0;
    beats_o[n] = '{data: op_eff, cle: 1'b1, ale: 1'b0};
    n++;
    if (col_vld_i) begin
      beats_o[n] = '{data: col_eff[7:0], cle: 1'b0, ale: 1'b1};
      n++;
      if (!narrow) begin
        beats_o[n] = '{data: col_eff[15:8], cle: 1'b0, ale: 1'b1};
        n++;
      end
    end
    if (row_vld_i) begin
      beats_o[n] = '{data: row_i[7:0], cle: 1'b0, ale: 1'b1};
      n++;
      beats_o[n] = '{data: row_i[15:8], cle: 1'b0, ale: 1'b1};
      n++;
      if (row3_i) begin
        beats_o[n] = '{data: row_i[23:16], cle: 1'b0, ale: 1'b1};
        n++;
      end
    end
    post_o = POST_RB;
    case (op_eff)
      OP_CACHE_PROG, OP_PROG, OP_ERASE_A, OP_ERASE_B,
      OP_DATA_IN, OP_STATUS, OP_ID, OP_SET_FEAT: post_o = POST_NONE;
      OP_RND_IN: post_o = post_ccs;
      OP_RND_OUT: begin
        beats_o[n] = '{data: OP_RNDO_CONF, cle: 1'b1, ale: 1'b0};
        n++;
        post_o = post_ccs;
      end
      OP_READ0: begin
        if (!col_vld_i && !row_vld_i) post_o = POST_NONE;
        else begin
          beats_o[n] = '{data: OP_RD_CONFIRM, cle: 1'b1, ale: 1'b0};
          n++;
        end
      end
      default: post_o = POST_RB;
    endcase
    count_o = CNT_W'(n);
  end
endmodule

// File: rtl/nand_lp_timer.sv
module nand_lp_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/nand_lp_seq.sv
module nand_lp_seq
  import nand_lp_pkg::*;
#(
  parameter int PAGE_BYTES      = 2048,
  parameter int CCS_W           = 8,
  parameter int DEFAULT_CCS_CYC = 125,
  parameter int TWB_CYC         = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [7:0]       req_op_i,
  input  logic             req_col_vld_i,
  input  logic [15:0]      req_col_i,
  input  logic             req_row_vld_i,
  input  logic [23:0]      req_row_i,
  input  logic             cfg_bus16_i,
  input  logic             cfg_row3_i,
  input  logic             cfg_ccs_en_i,
  input  logic [CCS_W-1:0] cfg_ccs_cyc_i,
  output logic             busy_o,
  output logic             beat_valid_o,
  input  logic             beat_ready_i,
  output logic [7:0]       beat_byte_o,
  output logic             beat_cle_o,
  output logic             beat_ale_o,
  output logic             wait_rb_o,
  input  logic             dev_rdy_i
);
  localparam int MAX_BEATS = 7;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  typedef enum logic [1:0] {S_IDLE, S_EMIT, S_DELAY, S_WAIT} state_e;

  state_e           state_q;
  beat_t            plan_beats [MAX_BEATS];
  logic [CNT_W-1:0] plan_cnt;
  post_e            plan_post;
  logic [15:0]      plan_ccs;

  beat_t            beats_q [MAX_BEATS];
  logic [CNT_W-1:0] cnt_q, idx_q;
  post_e            post_q;
  logic [15:0]      ccs_q;
  logic             rb_after_q;
  logic             accept, take, last_take, tmr_load, tmr_last;
  logic [15:0]      tmr_len;

  nand_lp_plan #(
    .PAGE_BYTES(PAGE_BYTES), .COL_W(16), .ROW_W(24), .CCS_W(CCS_W),
    .DEFAULT_CCS_CYC(DEFAULT_CCS_CYC), .MAX_BEATS(MAX_BEATS), .CNT_W(CNT_W)
  ) u_plan (
    .op_i(req_op_i), .col_vld_i(req_col_vld_i), .col_i(req_col_i),
    .row_vld_i(req_row_vld_i), .row_i(req_row_i), .bus16_i(cfg_bus16_i),
    .row3_i(cfg_row3_i), .ccs_en_i(cfg_ccs_en_i), .ccs_cyc_i(cfg_ccs_cyc_i),
    .beats_o(plan_beats), .count_o(plan_cnt), .post_o(plan_post), .ccs_len_o(plan_ccs)
  );

  assign accept    = (state_q == S_IDLE) && req_valid_i;
  assign take      = (state_q == S_EMIT) && beat_ready_i;
  assign last_take = take && (idx_q == cnt_q - 1'b1);
  assign tmr_load  = last_take && (post_q != POST_NONE);
  assign tmr_len   = (post_q == POST_CCS) ? ccs_q : 16'(TWB_CYC);

  nand_lp_timer #(.W(16)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .len_i(tmr_len), .last_o(tmr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      cnt_q      <= '0;
      post_q     <= POST_NONE;
      ccs_q      <= '0;
      rb_after_q <= 1'b0;
      for (int i = 0; i < MAX_BEATS; i++) beats_q[i] <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          beats_q <= plan_beats;
          cnt_q   <= plan_cnt;
          post_q  <= plan_post;
          ccs_q   <= plan_ccs;
          idx_q   <= '0;
          state_q <= S_EMIT;
        end
        S_EMIT: if (take) begin
          if (last_take) begin
            rb_after_q <= (post_q == POST_RB);
            state_q    <= (post_q == POST_NONE) ? S_IDLE : S_DELAY;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_DELAY: if (tmr_last) state_q <= rb_after_q ? S_WAIT : S_IDLE;
        S_WAIT:  if (dev_rdy_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign beat_valid_o = (state_q == S_EMIT);
  assign beat_byte_o  = beats_q[idx_q].data;
  assign beat_cle_o   = beats_q[idx_q].cle;
  assign beat_ale_o   = beats_q[idx_q].ale;
  assign wait_rb_o    = (state_q == S_WAIT);
endmodule

module nand_lp_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       beat_valid_o,
  input logic       beat_ready_i,
  input logic [7:0] beat_byte_o,
  input logic       beat_cle_o,
  input logic       beat_ale_o,
  input logic       wait_rb_o,
  input logic       dev_rdy_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_idle_r11: assert (!busy_o && !beat_valid_o && !wait_rb_o);
    end
  end

  p_hold_beat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_byte_o)
      && $stable(beat_cle_o) && $stable(beat_ale_o));

  p_valid_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> busy_o);

  p_flag_kind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> (beat_cle_o ^ beat_ale_o));

  p_wait_after_beats_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_rb_o |-> busy_o && !beat_valid_o);

  p_rdy_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_rb_o && dev_rdy_i |=> !busy_o);

  p_wait_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_rb_o && !dev_rdy_i |=> wait_rb_o);
endmodule

bind nand_lp_seq nand_lp_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .beat_valid_o(beat_valid_o),
  .beat_ready_i(beat_ready_i), .beat_byte_o(beat_byte_o), .beat_cle_o(beat_cle_o),
  .beat_ale_o(beat_ale_o), .wait_rb_o(wait_rb_o), .dev_rdy_i(dev_rdy_i)
);

// File: tb/nand_lp_seq_test.sv
module nand_lp_seq_test;
  localparam int PAGE = 2048;
  localparam int DEF  = 125;
  localparam int TWB  = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, col_vld = 0, row_vld = 0, b16 = 0, r3 = 0, ccs_en = 0;
  logic [7:0] op = 0, ccs_cyc = 0;
  logic [15:0] col = 0;
  logic [23:0] row = 0;
  logic busy, bv, br = 0, cle, ale, wrb, dev_rdy = 0;
  logic [7:0] bb;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  logic [9:0] eb [8];
  int ecnt, epost, edly;

  always #2 clk = ~clk;

  nand_lp_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(op),
    .req_col_vld_i(col_vld), .req_col_i(col), .req_row_vld_i(row_vld), .req_row_i(row),
    .cfg_bus16_i(b16), .cfg_row3_i(r3), .cfg_ccs_en_i(ccs_en), .cfg_ccs_cyc_i(ccs_cyc),
    .busy_o(busy), .beat_valid_o(bv), .beat_ready_i(br), .beat_byte_o(bb),
    .beat_cle_o(cle), .beat_ale_o(ale), .wait_rb_o(wrb), .dev_rdy_i(dev_rdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] o);
    case (o)
      8'h00, 8'h50: return "R5";
      8'h05: return "R6";
      8'h85: return "R7";
      8'h15, 8'h10, 8'h60, 8'hD0, 8'h80, 8'h70, 8'h90, 8'hEF: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic add_beat(input logic [7:0] d, input bit c);
    eb[ecnt] = {d, c, ~c};
    ecnt++;
  endtask

  // expected beats and tail from R1..R9
  task automatic model();
    logic [7:0] o;
    logic [15:0] c;
    bit narrow;
    o = op; c = col;
    if (op == 8'h50) begin o = 8'h00; c = col + 16'(PAGE); end  // R1
    narrow = (o == 8'h90) || (o == 8'hEC) || (o == 8'hEE) || (o == 8'hEF);
    if (b16 && !narrow) c = c >> 1;  // R3
    ecnt = 0;
    add_beat(o, 1);
    if (col_vld) begin
      add_beat(c[7:0], 0);
      if (!narrow) add_beat(c[15:8], 0);  // R2
    end
    if (row_vld) begin
      add_beat(row[7:0], 0);
      add_beat(row[15:8], 0);
      if (r3) add_beat(row[23:16], 0);  // R4
    end
    edly = (ccs_cyc == 0) ? DEF : int'(ccs_cyc);
    case (o)
      8'h15, 8'h10, 8'h60, 8'hD0, 8'h80, 8'h70, 8'h90, 8'hEF: epost = 0;
      8'h85: epost = ccs_en ? 1 : 0;
      8'h05: begin add_beat(8'hE0, 1); epost = ccs_en ? 1 : 0; end
      8'h00: begin
        if (!col_vld && !row_vld) epost = 0;
        else begin add_beat(8'h30, 1); epost = 2; end
      end
      default: epost = 2;
    endcase
    if (epost == 0) edly = 0;
    if (epost == 2) edly = TWB;
  endtask

  task automatic run(input bit stall);
    string t;
    int got, n, guard, hold;
    logic [9:0] prev;
    bit prev_stall;
    t = tag_of(op);
    model();
    @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    got = 0; guard = 0; prev_stall = 0; prev = '0;
    while (got < ecnt && guard < 100) begin
      if (prev_stall) chk(bv && {bb, cle, ale} == prev, "R10 stalled beat held", {bb, cle, ale}, prev);
      br = stall ? 1'($urandom_range(0, 1)) : 1'b1;
      if (bv && br) begin
        chk({bb, cle, ale} == eb[got], $sformatf("R2/R3/R4 %s beat %0d op %0h", t, got, op),
            {bb, cle, ale}, eb[got]);
        got++;
      end
      prev_stall = bv && !br;
      prev = {bb, cle, ale};
      @(negedge clk);
      guard++;
    end
    br = 0;
    chk(got == ecnt, {t, " beat count"}, got, ecnt);
    n = 0; guard = 0;
    while (busy && !wrb && guard < 400) begin
      if (bv) chk(0, {t, " extra beat"}, 1, 0);
      n++; guard++;
      @(negedge clk);
    end
    chk(n == edly, {t, " tail busy cycles"}, n, edly);
    chk(wrb == (epost == 2), {t, " ready wait entry"}, wrb, epost == 2);
    if (wrb) begin
      hold = $urandom_range(0, 5);
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(busy && wrb, {t, " R5 holds until ready"}, busy, 1);
      end
      dev_rdy = 1;
      @(negedge clk);
      dev_rdy = 0;
      chk(!busy && !wrb, {t, " R9 release after ready"}, busy, 0);
    end
  endtask

  task automatic set_req(input logic [7:0] o, input bit cv, input logic [15:0] c,
                         input bit rv, input logic [23:0] r);
    op = o; col_vld = cv; col = c; row_vld = rv; row = r;
  endtask

  task automatic set_cfg(input bit w16, input bit rr3, input bit en, input logic [7:0] cy);
    b16 = w16; r3 = rr3; ccs_en = en; ccs_cyc = cy;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  localparam logic [7:0] OPS [16] = '{8'h00, 8'h50, 8'h05, 8'h85, 8'h10, 8'h15, 8'h60, 8'hD0,
                                      8'h80, 8'h70, 8'h90, 8'hEF, 8'hEE, 8'hEC, 8'hFF, 8'h31};

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !bv && !wrb, "R11 reset idle", {busy, bv, wrb}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bv && !wrb, "R11 idle after release", {busy, bv, wrb}, 0);

    set_cfg(0, 0, 1, 0);
    set_req(8'h50, 1, 16'h0010, 1, 24'h000123); run(0);   // R1
    set_req(8'h50, 1, 16'hF900, 0, 0); run(0);             // R1 wrap
    set_req(8'h90, 1, 16'h0020, 0, 0); run(0);             // R2 one column byte
    set_req(8'h00, 1, 16'hA55A, 1, 24'h345678); run(1);    // R2 two bytes, R10 stalls
    set_cfg(1, 0, 1, 0);
    set_req(8'h00, 1, 16'h0403, 1, 24'h000001); run(0);    // R3 halved
    set_req(8'hEF, 1, 16'h0081, 0, 0); run(0);             // R3 not halved
    set_cfg(0, 1, 1, 0);
    set_req(8'h60, 0, 0, 1, 24'hABCDEF); run(0);           // R4 three row bytes, R8
    set_req(8'h00, 0, 0, 0, 0); run(0);                    // R5 no address
    set_req(8'h00, 0, 0, 1, 24'h000777); run(0);           // R5 row only
    set_cfg(0, 0, 1, 8'd7);
    set_req(8'h05, 1, 16'h0100, 0, 0); run(1);             // R6
    set_cfg(0, 0, 1, 0);
    set_req(8'h85, 1, 16'h0200, 0, 0); run(0);             // R7 default delay
    set_cfg(0, 0, 0, 8'd9);
    set_req(8'h85, 1, 16'h0200, 0, 0); run(0);             // R7 disabled
    set_req(8'h05, 1, 16'h0300, 0, 0); run(0);             // R7 disabled on output
    set_cfg(0, 0, 1, 8'd1);
    set_req(8'h85, 0, 0, 0, 0); run(0);                    // R7 one cycle
    set_req(8'h10, 0, 0, 0, 0); run(0);                    // R8
    set_req(8'hFF, 0, 0, 0, 0); run(0);                    // R9 reset opcode

    for (int i = 0; i < 300; i++) begin
      set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
              ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 20)));
      set_req(OPS[$urandom_range(0, 15)], 1'($urandom_range(0, 1)), 16'($urandom()),
              1'($urandom_range(0, 1)), 24'($urandom()));
      run(1'($urandom_range(0, 1)));
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule